// File: doc/BRIEF.md
# Luma Capture Controller

This block sits between a digital video decoder and a processor. It receives the decoder's 8-bit byte stream together with the pixel clock, a line-active reference, a field-start reference and an odd/even field flag. Chroma and luma bytes arrive interleaved, and the block keeps only the luma (grey) samples. It counts rows and columns from the sync inputs, merges the two interlaced fields into one frame, and crops a window whose size is set by parameters (256x256 by default). Each pixel inside the window goes out through a RAM write port to an external frame memory.

A processor drives a small register port. Through it the processor sets the window's row and column offsets, issues a START command, polls status, and reads captured pixels by address. The frame memory has two banks. A capture fills the hidden bank, and the banks swap when the frame is complete. Processor pixel reads therefore always see the last complete frame, even while a new capture is running. Everything runs in the decoder's pixel clock domain.

Top module: `luma_capture`

## Requirements
- R1: Byte positions in an active line are counted from 0 at the first byte where the line reference is high. Only odd positions (luma) can be written, and the written data equals that input byte. Even positions (chroma) are never written.
- R2: A window line r (counted from 0) of the odd field goes to frame row 2r+1, and window line r of the even field goes to frame row 2r. The RAM write address is {bank bit, frame row (log2 WIN_H bits), frame column (log2 WIN_W bits)}.
- R3: The column of a luma sample is the number of luma samples before it in the same line. The row of a line is the number of falling edges of the line reference since the last rising edge of the field reference.
- R4: A sample is written only when row_offset <= row < row_offset + WIN_H/2 and col_offset <= column < col_offset + WIN_W. Its frame column is column - col_offset. The default window is 256x256.
- R5: Writing a value with bit 0 set to register 0 (cpu_addr top bit 0, low two bits 00) arms a capture. Nothing is written while armed, and capture starts at the first field-reference rising edge that has vin_odd = 1.
- R6: During odd-field capture, a field edge with vin_odd = 0 moves capture to the even field. A field edge with vin_odd = 1 restarts the odd field.
- R7: Register 0 reads back BUSY in bit 0 and DONE in bit 1. DONE sets, and BUSY clears, on the falling line edge that ends the last window row of the even field. START clears DONE and sets BUSY.
- R8: Captured pixels are written to the bank opposite the display bank, and the two banks swap when DONE sets. A pixel read (cpu_addr top bit 1, low bits give the frame address) returns data from the display bank, so reads made during a capture return the previous frame.
- R9: Register 1 holds the row offset and register 2 holds the column offset. Both read back as written. Read data for any read appears on cpu_rdata one cycle after cpu_rd.
- R10: After reset the status, both offsets and the display bank are 0, and no RAM write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vin_data | input | 8 | Interleaved chroma/luma byte stream |
| vin_line | input | 1 | High during active bytes of a line |
| vin_field | input | 1 | Rising edge marks the start of a field |
| vin_odd | input | 1 | 1 while the odd field is being delivered |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | CPU_AW (17) | Top bit selects pixel space; otherwise low two bits pick a register |
| cpu_wdata | input | CNT_W (10) | Register write data |
| cpu_rdata | output | CNT_W (10) | Read data, valid one cycle after cpu_rd |
| ram_we | output | 1 | Frame RAM write enable |
| ram_waddr | output | PIX_AW+1 (17) | Frame RAM write address {bank, row, col} |
| ram_wdata | output | 8 | Frame RAM write data (luma) |
| ram_raddr | output | PIX_AW+1 (17) | Frame RAM read address {display bank, pixel} |
| ram_rdata | input | 8 | Frame RAM read data, one cycle after ram_raddr |

## Verification
On every cycle, the assertions check that each write carries the luma byte from the previous cycle, that rows from odd-field capture land on odd frame rows and rows from even-field capture on even rows, that nothing is written while idle or armed, that writes never target the display bank, that DONE and BUSY never hold together, and that the banks swap exactly when DONE rises. The bench's scenarios cover the rest. They check exact row and column arithmetic with offsets at the window edges, that an even field or an unarmed odd field leaves memory untouched, that an odd field restarts when repeated, and that a pixel read in the middle of a capture returns the previous frame's value.

// File: rtl/luma_capture.sv
module luma_capture #(
  parameter int WIN_W  = 256,
  parameter int WIN_H  = 256,
  parameter int CNT_W  = 10,
  localparam int COL_W  = $clog2(WIN_W),
  localparam int ROW_W  = $clog2(WIN_H),
  localparam int PIX_AW = ROW_W + COL_W,
  localparam int CPU_AW = PIX_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        vin_data,
  input  logic              vin_line,
  input  logic              vin_field,
  input  logic              vin_odd,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CNT_W-1:0]  cpu_wdata,
  output logic [CNT_W-1:0]  cpu_rdata,
  output logic              ram_we,
  output logic [PIX_AW:0]   ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic [PIX_AW:0]   ram_raddr,
  input  logic [7:0]        ram_rdata
);
  localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(WIN_H / 2);
  localparam logic [CNT_W-1:0] W_LIM    = CNT_W'(WIN_W);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_ODD, S_EVEN} st_t;
  st_t st;

  logic ph, line_q, field_q, done, fb, rd_pix_q;
  logic [CNT_W-1:0] col, row, roff, coff, reg_q;

  logic fedge, lfall, is_y, in_win, capturing, wr_pix, reg_wr, start, last_line, busy;
  logic [CNT_W-1:0] rrel, crel;
  logic [ROW_W-1:0] frow;

  assign fedge     = vin_field & ~field_q;
  assign lfall     = ~vin_line & line_q;
  assign is_y      = vin_line & ph;
  assign rrel      = row - roff;
  assign crel      = col - coff;
  assign in_win    = (row >= roff) && (rrel < HALF_LIM) && (col >= coff) && (crel < W_LIM);
  assign capturing = (st == S_ODD) || (st == S_EVEN);
  assign wr_pix    = is_y && capturing && in_win && !fedge;
  assign frow      = {rrel[ROW_W-2:0], st == S_ODD};
  assign reg_wr    = cpu_wr && !cpu_addr[PIX_AW];
  assign start     = reg_wr && (cpu_addr[1:0] == 2'd0) && cpu_wdata[0];
  assign last_line = lfall && (row >= roff) && (rrel == HALF_LIM - 1'b1);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 1'b0;
      line_q <= 1'b0;
      field_q <= 1'b0;
      col <= '0;
      row <= '0;
    end else begin
      line_q  <= vin_line;
      field_q <= vin_field;
      ph      <= vin_line ? ~ph : 1'b0;
      if (!vin_line)                  col <= '0;
      else if (is_y && col != '1)     col <= col + 1'b1;
      if (fedge)                      row <= '0;
      else if (lfall && row != '1)    row <= row + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      fb <= 1'b0;
      roff <= '0;
      coff <= '0;
    end else begin
      if (reg_wr && cpu_addr[1:0] == 2'd1) roff <= cpu_wdata;
      if (reg_wr && cpu_addr[1:0] == 2'd2) coff <= cpu_wdata;
      if (start) begin
        st   <= S_ARM;
        done <= 1'b0;
      end else begin
        case (st)
          S_ARM:  if (fedge && vin_odd)  st <= S_ODD;
          S_ODD:  if (fedge && !vin_odd) st <= S_EVEN;
          S_EVEN: if (last_line) begin
            st   <= S_IDLE;
            done <= 1'b1;
            fb   <= ~fb;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= wr_pix;
      if (wr_pix) begin
        ram_waddr <= {~fb, frow, crel[COL_W-1:0]};
        ram_wdata <= vin_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pix_q <= 1'b0;
      reg_q    <= '0;
    end else begin
      rd_pix_q <= cpu_rd && cpu_addr[PIX_AW];
      if (cpu_rd) begin
        case (cpu_addr[1:0])
          2'd0:    reg_q <= {{(CNT_W-2){1'b0}}, done, busy};
          2'd1:    reg_q <= roff;
          2'd2:    reg_q <= coff;
          default: reg_q <= '0;
        endcase
      end
    end
  end

  assign ram_raddr = {fb, cpu_addr[PIX_AW-1:0]};
  assign cpu_rdata = rd_pix_q ? {{(CNT_W-8){1'b0}}, ram_rdata} : reg_q;
endmodule

// File: rtl/luma_capture_chk.sv
module luma_capture_chk #(
  parameter int PIX_AW = 16,
  parameter int COL_W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      st,
  input logic            done,
  input logic            fb,
  input logic            ram_we,
  input logic [PIX_AW:0] ram_waddr,
  input logic [7:0]      ram_wdata,
  input logic [7:0]      vin_data,
  input logic            vin_line,
  input logic            cpu_wr,
  input logic [PIX_AW:0] cpu_addr,
  input logic            cpu_wdata0
);
  a_r1_luma_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(vin_line) && ram_wdata == $past(vin_data)));

  a_r2_odd_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(st) == 2'd2) |-> ram_waddr[COL_W]);

  a_r2_even_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(st) == 2'd3) |-> !ram_waddr[COL_W]);

  a_r5_no_write_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 || st == 2'd1) |=> !ram_we);

  a_r7_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> !done);

  a_r7_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[PIX_AW] && cpu_addr[1:0] == 2'd0 && cpu_wdata0) |=> (!done && st == 2'd1));

  a_r8_hidden_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_waddr[PIX_AW] != fb));

  a_r8_swap_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (fb != $past(fb)));
endmodule

bind luma_capture luma_capture_chk #(.PIX_AW(PIX_AW), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .done(done), .fb(fb),
  .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
  .vin_data(vin_data), .vin_line(vin_line),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata0(cpu_wdata[0])
);

// File: tb/tb_luma_capture.sv
`timescale 1ns/1ps
module tb_luma_capture;
  localparam int W = 8, H = 8, CW = 10, PA = 6, CA = 7;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [7:0] vin_data;
  logic vin_line, vin_field, vin_odd, cpu_wr, cpu_rd, ram_we;
  logic [CA-1:0] cpu_addr;
  logic [CW-1:0] cpu_wdata, cpu_rdata;
  logic [PA:0] ram_waddr, ram_raddr;
  logic [7:0] ram_wdata, ram_rdata;

  luma_capture #(.WIN_W(W), .WIN_H(H), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .vin_data(vin_data), .vin_line(vin_line),
    .vin_field(vin_field), .vin_odd(vin_odd), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata));

  logic [7:0] ram [0:127];
  always @(posedge clk) begin
    if (ram_we) ram[ram_waddr] <= ram_wdata;
    ram_rdata <= ram[ram_raddr];
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  // driven values for the next cycle
  int d_data = 0; bit d_line = 0, d_field = 0, d_odd = 0;
  bit c_wr = 0, c_rd = 0; int c_addr = 0, c_wd = 0; string c_tag = "";

  // reference model
  int m_mem [0:127];
  int m_ph, m_col, m_row, m_pl, m_pf, m_st, m_fb, m_done, m_roff, m_coff;
  bit e_we; int e_addr, e_data;
  bit p_rd; int p_val; string p_tag;

  task automatic fail(string tag, int act, int exp);
    errors++;
    $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
  endtask

  task automatic step();
    int rr, cr, fe, lf, isy, win, last;
    @(negedge clk);
    checks++;
    if (ram_we !== e_we) fail("R1/R4/R5 write enable", ram_we, e_we);
    else if (e_we) begin
      checks++;
      if (int'(ram_waddr) != e_addr) fail("R2/R3 write address", ram_waddr, e_addr);
      checks++;
      if (int'(ram_wdata) != e_data) fail("R1 write data", ram_wdata, e_data);
    end
    if (p_rd) begin
      checks++;
      if (int'(cpu_rdata) != p_val) fail(p_tag, cpu_rdata, p_val);
      p_rd = 0;
    end
    vin_data = d_data[7:0]; vin_line = d_line; vin_field = d_field; vin_odd = d_odd;
    cpu_wr = c_wr; cpu_rd = c_rd; cpu_addr = c_addr[CA-1:0]; cpu_wdata = c_wd[CW-1:0];
    fe  = d_field && !m_pf;
    lf  = !d_line && m_pl;
    isy = d_line && m_ph;
    rr  = m_row - m_roff;
    cr  = m_col - m_coff;
    win = (rr >= 0) && (rr < H/2) && (cr >= 0) && (cr < W);
    e_we = isy && (m_st >= 2) && win && !fe;
    if (e_we) begin
      e_addr = ((1 - m_fb) << 6) | ((2*rr + (m_st == 2 ? 1 : 0)) << 3) | cr;
      e_data = d_data & 255;
      m_mem[e_addr] = e_data;
    end
    if (c_rd) begin
      p_rd = 1; p_tag = c_tag;
      if (c_addr[6]) p_val = m_mem[(m_fb << 6) | (c_addr & 63)];
      else case (c_addr & 3)
        0: p_val = m_done*2 + (m_st != 0 ? 1 : 0);
        1: p_val = m_roff;
        2: p_val = m_coff;
        default: p_val = 0;
      endcase
    end
    last = lf && (rr == H/2 - 1);
    if (c_wr && !c_addr[6] && (c_addr & 3) == 1) m_roff = c_wd;
    if (c_wr && !c_addr[6] && (c_addr & 3) == 2) m_coff = c_wd;
    if (c_wr && !c_addr[6] && (c_addr & 3) == 0 && c_wd[0]) begin
      m_st = 1; m_done = 0;
    end else if (m_st == 1 && fe && d_odd) m_st = 2;
    else if (m_st == 2 && fe && !d_odd) m_st = 3;
    else if (m_st == 3 && last) begin m_st = 0; m_done = 1; m_fb = 1 - m_fb; end
    m_ph  = d_line ? !m_ph : 0;
    m_col = d_line ? m_col + isy : 0;
    m_row = fe ? 0 : (lf ? m_row + 1 : m_row);
    m_pl = d_line; m_pf = d_field;
    c_wr = 0; c_rd = 0;
  endtask

  task automatic cpu_write(int addr, int wd);
    c_wr = 1; c_addr = addr; c_wd = wd; step();
  endtask

  task automatic cpu_read(int addr, string tag);
    c_rd = 1; c_addr = addr; c_tag = tag; step(); step();
  endtask

  // one active line: Cb,Y,Cr,Y...; optional pixel read in blanking
  task automatic send_line(int seed, int ny, int rd_pix);
    d_line = 1;
    for (int j = 0; j < ny; j++) begin
      d_data = 8'hE0 ^ j; step();
      d_data = (seed + j) & 255; step();
    end
    d_line = 0; d_data = 0;
    if (rd_pix >= 0) begin c_rd = 1; c_addr = 64 | rd_pix; c_tag = "R8 read during capture"; end
    step(); step(); step();
  endtask

  task automatic send_field(bit odd, int seed, int rd_pix);
    d_odd = odd; d_field = 1; d_line = 0; step();
    d_field = 0; step(); step();
    for (int l = 0; l < 8; l++) send_line(seed + 16*l, 12, (l == 3) ? rd_pix : -1);
  endtask

  task automatic read_frame(string tag);
    for (int i = 0; i < 64; i++) cpu_read(64 | i, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin ram[i] = 8'h00; m_mem[i] = 0; end
    m_ph = 0; m_col = 0; m_row = 0; m_pl = 0; m_pf = 0; m_st = 0;
    m_fb = 0; m_done = 0; m_roff = 0; m_coff = 0; e_we = 0; p_rd = 0;
    rst_n = 0; vin_data = 0; vin_line = 0; vin_field = 0; vin_odd = 0;
    cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    cpu_read(0, "R10 reset status");
    cpu_read(1, "R10 reset row offset");
    cpu_read(64 | 5, "R10 reset pixel");
    // R9 offsets
    cpu_write(1, 2);
    cpu_write(2, 1);
    cpu_read(1, "R9 row offset readback");
    cpu_read(2, "R9 col offset readback");
    // R5: unarmed odd field writes nothing
    send_field(1, 8'h05, -1);
    cpu_write(0, 1);
    cpu_read(0, "R7 busy after start");
    // R5: armed but even field writes nothing
    send_field(0, 8'h25, -1);
    // R6: odd, odd again (restart), then even; R2/R3/R4 per-cycle
    send_field(1, 8'h10, -1);
    cpu_read(0, "R7 busy during odd");
    send_field(1, 8'h40, -1);
    send_field(0, 8'h70, -1);
    cpu_read(0, "R7 done after even field");
    read_frame("R8 first frame readback");
    // second capture; reads mid-capture return previous frame
    cpu_write(0, 1);
    cpu_read(0, "R7 start clears done");
    send_field(1, 8'h90, 9);
    send_field(0, 8'hB0, 22);
    cpu_read(0, "R7 done second frame");
    read_frame("R8 second frame readback");
    // window at offset 0: covers column 0 / row 0 edges
    cpu_write(1, 0);
    cpu_write(2, 0);
    cpu_write(0, 1);
    send_field(1, 8'h33, -1);
    send_field(0, 8'h55, -1);
    cpu_read(0, "R7 done third frame");
    read_frame("R4 zero-offset frame readback");
    step(); step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule